// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This block turns word and byte load/store requests from a processor datapath into accesses of a 32-bit-wide data memory. The memory is byte addressed, so consecutive words are 4 addresses apart. Each request carries an operation, a base register value, a 16-bit signed displacement and store data. The unit adds the sign-extended displacement to the base to form the effective address. For word operations it moves a whole word. For byte operations it picks one byte lane, using big-endian ordering: the byte at the lowest address of a word is that word's most significant byte.

The word storage sits inside the unit and has a synchronous read. Requests enter through a valid/ready handshake. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. One cycle after acceptance, a response appears on the `rsp_*` outputs. Every request produces a response, including stores. A response stays on the outputs unchanged until `rsp_ready` is high. While a response is waiting, `req_ready` is low. Back-pressure from `rsp_ready` therefore stalls the request side with no loss of data. The `mem_*` outputs show the write that the current request would perform. They update combinationally from the request.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address on `mem_addr` equals `req_base` plus `req_offset` sign-extended to 32 bits, with wrap-around modulo 2^32.
- R2: An accepted word store (`req_op`=01) whose address bits 1:0 are 00 asserts `mem_we` with `mem_strb`=1111 and `mem_wdata`=`req_wdata`, and replaces the whole addressed word.
- R3: An accepted byte store (`req_op`=11) drives `req_wdata[7:0]` onto all four byte lanes of `mem_wdata` and asserts exactly one strobe. Address bits 1:0 = 0,1,2,3 select strobe bit 3,2,1,0 respectively (bits 31:24 down to 7:0). Only that byte of the word changes.
- R4: An accepted word load (`req_op`=00) at an aligned address returns the whole stored word on `rsp_rdata` in the cycle after acceptance.
- R5: An accepted byte load (`req_op`=10) returns the byte at the big-endian lane selected by address bits 1:0 in `rsp_rdata[7:0]`, with bit 7 copied into bits 31:8.
- R6: A word load or word store whose address bits 1:0 are not 00 sets `rsp_misaligned`. Such a store writes nothing (`mem_we` stays low) and such a load returns zero. Byte operations never set the flag. Responses to stores carry `rsp_rdata`=0.
- R7: `req_ready` is high when no response is pending or when `rsp_ready` is high. Each accepted request gives `rsp_valid` in the next cycle. A response held by a low `rsp_ready` keeps its data and flag stable. `mem_we` is high only on an accepted request.
- R8: The word storage has MEM_WORDS entries, indexed by address bits [log2(MEM_WORDS)+1:2]. Higher address bits are ignored, so addresses that differ only in those bits reach the same word.
- R9: Reset (active-low `rst_n`) clears `rsp_valid` and zeroes every stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_op | input | 2 | 00 word load, 01 word store, 10 byte load, 11 byte store |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register |
| mem_addr | output | 32 | Effective byte address |
| mem_we | output | 1 | Memory write this cycle |
| mem_strb | output | 4 | Byte write strobes, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-placed write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Load result |
| rsp_misaligned | output | 1 | Word access was not 4-byte aligned |

## Verification
On every cycle the assertions check the handshake: writes happen only on an accepted request, a response follows each acceptance, and a stalled response stays stable. They also check strobe shape on each store, the write veto for misaligned word stores, and the misaligned flag. The bench keeps a behavioural byte-array model of memory. Only its scenarios show data correctness. That covers the big-endian lane mapping of byte loads and stores, sign extension, address wrap onto the same word, a held response surviving a refused request, and storage being zero after reset.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    OP_LW = 2'b00,
    OP_SW = 2'b01,
    OP_LB = 2'b10,
    OP_SB = 2'b11
  } lsu_op_e;

  typedef struct packed {
    logic       is_store;
    logic       is_byte;
    logic       misaligned;
    logic [1:0] lane;
  } rsp_meta_t;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANE_W = 2
) (
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] ea,
  output logic              is_store,
  output logic              is_byte,
  output logic              misaligned
);
  localparam int EXT_W = ADDR_W - OFF_W;

  always_comb begin
    ea         = base + {{EXT_W{offset[OFF_W-1]}}, offset};
    is_byte    = op[1];
    is_store   = op[0];
    misaligned = !is_byte && (ea[LANE_W-1:0] != '0);
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
  parameter int DATA_W = 32,
  parameter int NB     = DATA_W / 8,
  parameter int LANE_W = $clog2(NB)
) (
  input  logic              fire,
  input  logic              is_store,
  input  logic              is_byte,
  input  logic              misaligned,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] src,
  output logic              we,
  output logic [NB-1:0]     strb,
  output logic [DATA_W-1:0] wdata
);
  logic [NB-1:0] lane_sel;

  // big-endian: lane 0 is the most significant byte
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign lane_sel[NB-1-i] = is_byte ? (lane == LANE_W'(i)) : 1'b1;
  end

  always_comb begin
    we    = fire && is_store && !misaligned;
    strb  = we ? lane_sel : '0;
    wdata = is_byte ? {NB{src[7:0]}} : src;
  end
endmodule

// File: rtl/lsu_word_mem.sv
module lsu_word_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int NB     = DATA_W / 8,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [NB-1:0]     strb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) store_q[w] <= '0;
      rdata <= '0;
    end else begin
      if (we) begin
        for (int b = 0; b < NB; b++)
          if (strb[b]) store_q[idx][8*b +: 8] <= wdata[8*b +: 8];
      end
      if (re) rdata <= store_q[idx];
    end
  end
endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane #(
  parameter int DATA_W = 32,
  parameter int NB     = DATA_W / 8,
  parameter int LANE_W = $clog2(NB)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [LANE_W-1:0] lane,
  input  logic              is_byte,
  input  logic              zero_out,
  output logic [DATA_W-1:0] result
);
  logic [7:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NB; i++)
      if (lane == LANE_W'(i)) picked = word[8*(NB-1-i) +: 8];
    if (zero_out)     result = '0;
    else if (is_byte) result = {{(DATA_W-8){picked[7]}}, picked};
    else              result = word;
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int OFF_W     = 16,
  parameter int MEM_WORDS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic [ADDR_W-1:0]   req_base,
  input  logic [OFF_W-1:0]    req_offset,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_we,
  output logic [DATA_W/8-1:0] mem_strb,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_misaligned
);
  import lsu_pkg::*;

  localparam int NB     = DATA_W / 8;
  localparam int LANE_W = $clog2(NB);
  localparam int IDX_W  = $clog2(MEM_WORDS);

  logic              fire, is_store, is_byte, misaligned;
  logic [ADDR_W-1:0] ea;
  logic [DATA_W-1:0] rd_word;
  logic              rsp_valid_q;
  rsp_meta_t         meta_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign mem_addr  = ea;

  lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_agen (
    .op(req_op), .base(req_base), .offset(req_offset), .ea(ea),
    .is_store(is_store), .is_byte(is_byte), .misaligned(misaligned)
  );

  lsu_store_lane #(.DATA_W(DATA_W)) u_slane (
    .fire(fire), .is_store(is_store), .is_byte(is_byte), .misaligned(misaligned),
    .lane(ea[LANE_W-1:0]), .src(req_wdata),
    .we(mem_we), .strb(mem_strb), .wdata(mem_wdata)
  );

  lsu_word_mem #(.DATA_W(DATA_W), .DEPTH(MEM_WORDS)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .strb(mem_strb),
    .idx(ea[LANE_W +: IDX_W]), .wdata(mem_wdata),
    .re(fire && !is_store), .rdata(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      meta_q      <= '0;
    end else if (fire) begin
      rsp_valid_q       <= 1'b1;
      meta_q.is_store   <= is_store;
      meta_q.is_byte    <= is_byte;
      meta_q.misaligned <= misaligned;
      meta_q.lane       <= ea[1:0];
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  lsu_load_lane #(.DATA_W(DATA_W)) u_llane (
    .word(rd_word), .lane(meta_q.lane[LANE_W-1:0]), .is_byte(meta_q.is_byte),
    .zero_out(meta_q.is_store || meta_q.misaligned), .result(rsp_rdata)
  );

  assign rsp_valid      = rsp_valid_q;
  assign rsp_misaligned = rsp_valid_q && meta_q.misaligned;
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [1:0]          req_op,
  input logic [DATA_W-1:0]   req_wdata,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic                mem_we,
  input logic [DATA_W/8-1:0] mem_strb,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [DATA_W-1:0]   rsp_rdata,
  input logic                rsp_misaligned
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_we_only_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> acc);
  assert_ready_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
  assert_rsp_follows_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  assert_rsp_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_misaligned)));
  assert_sb_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'b11) |-> ($countones(mem_strb) == 1 && mem_wdata[7:0] == req_wdata[7:0]));
  assert_sw_full_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'b01 && mem_addr[1:0] == 2'b00) |-> (mem_we && &mem_strb && mem_wdata == req_wdata));
  assert_sw_misaligned_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'b01 && mem_addr[1:0] != 2'b00) |-> (!mem_we && mem_strb == '0));
  assert_word_misaligned_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_op[1] && mem_addr[1:0] != 2'b00) |=> rsp_misaligned);
endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_we(mem_we), .mem_strb(mem_strb),
  .mem_wdata(mem_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_misaligned(rsp_misaligned)
);

// File: tb/lsu_lane_unit_bench.sv
`timescale 1ns/1ps
module lsu_lane_unit_bench;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready;
  logic [1:0]  req_op = 0;
  logic [31:0] req_base = 0, req_wdata = 0;
  logic [15:0] req_offset = 0;
  logic [31:0] mem_addr, mem_wdata, rsp_rdata;
  logic        mem_we, rsp_valid, rsp_misaligned;
  logic        rsp_ready = 1;
  logic [3:0]  mem_strb;

  int compared = 0, mismatched = 0;
  logic [7:0] ref_mem [256];  // byte-addressed model, 64 words

  always #2.5 clk = ~clk;

  lsu_lane_unit u_lsu_lane_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_strb(mem_strb), .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_misaligned(rsp_misaligned)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_word(input logic [31:0] a);
    logic [7:0] w = {a[7:2], 2'b00};
    return {ref_mem[w], ref_mem[w+8'd1], ref_mem[w+8'd2], ref_mem[w+8'd3]};
  endfunction

  // one request, checked on the request cycle and the response cycle
  task automatic do_op(input logic [1:0] op, input logic [31:0] base,
                       input logic [15:0] off, input logic [31:0] wd, input string tag);
    logic [31:0] ea, exp_rd, exp_wd;
    logic        mis, exp_we;
    logic [3:0]  exp_strb;
    logic [7:0]  b;
    ea  = base + {{16{off[15]}}, off};
    mis = !op[1] && (ea[1:0] != 2'b00);
    exp_we   = op[0] && !mis;
    exp_strb = !exp_we ? 4'h0 : (op[1] ? (4'b1000 >> ea[1:0]) : 4'hF);
    exp_wd   = op[1] ? {4{wd[7:0]}} : wd;
    exp_rd   = 32'h0;
    if (!op[0] && !mis) begin
      if (op[1]) begin b = ref_mem[ea[7:0]]; exp_rd = {{24{b[7]}}, b}; end
      else exp_rd = ref_word(ea);
    end
    @(negedge clk);
    req_valid = 1; req_op = op; req_base = base; req_offset = off; req_wdata = wd;
    #1;
    check({tag, " R7 req_ready"}, {31'b0, req_ready}, 32'd1);
    check({tag, " R1 mem_addr"}, mem_addr, ea);
    check({tag, " R2/R6 mem_we"}, {31'b0, mem_we}, {31'b0, exp_we});
    check({tag, " R3 mem_strb"}, {28'b0, mem_strb}, {28'b0, exp_strb});
    if (exp_we) check({tag, " R3 mem_wdata"}, mem_wdata, exp_wd);
    if (exp_we) begin
      if (op[1]) ref_mem[ea[7:0]] = wd[7:0];
      else for (int k = 0; k < 4; k++) ref_mem[{ea[7:2], 2'b00} + 8'(k)] = wd[31-8*k -: 8];
    end
    @(negedge clk);
    req_valid = 0;
    #1;
    check({tag, " R7 rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
    check({tag, " R4/R5 rsp_rdata"}, rsp_rdata, exp_rd);
    check({tag, " R6 rsp_misaligned"}, {31'b0, rsp_misaligned}, {31'b0, mis});
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    check("R9 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk); #1;
    check("R9 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    check("R7 ready idle", {31'b0, req_ready}, 32'd1);

    do_op(2'b00, 32'h0000_00A0, 16'h0004, 0, "R9 cleared word");
    do_op(2'b01, 32'h0000_0100, 16'h0010, 32'hCAFE_BABE, "R1 R2 sw");
    do_op(2'b00, 32'h0000_0110, 16'h0000, 0, "R4 lw");
    do_op(2'b01, 32'h0000_0020, 16'hFFFC, 32'h1357_9BDF, "R1 neg offset sw");
    do_op(2'b00, 32'h0000_001C, 16'h0000, 0, "R4 lw neg");
    do_op(2'b11, 32'h0000_0040, 16'h0000, 32'h0000_0081, "R3 sb lane0");
    do_op(2'b11, 32'h0000_0040, 16'h0001, 32'hFFFF_FF12, "R3 sb lane1");
    do_op(2'b11, 32'h0000_0040, 16'h0002, 32'h0000_0093, "R3 sb lane2");
    do_op(2'b11, 32'h0000_0040, 16'h0003, 32'h0000_0034, "R3 sb lane3");
    do_op(2'b00, 32'h0000_0040, 16'h0000, 0, "R3 word after sb");
    check("R3 big-endian word", ref_word(32'h40), 32'h8112_9334);
    for (int l = 0; l < 4; l++)
      do_op(2'b10, 32'h0000_0040, 16'(l), 0, "R5 lb");
    do_op(2'b11, 32'h0000_0110, 16'h0002, 32'h0000_0055, "R3 sb into word");
    do_op(2'b00, 32'h0000_0110, 16'h0000, 0, "R3 other bytes kept");
    do_op(2'b01, 32'h0000_0040, 16'h0001, 32'hDEAD_BEEF, "R6 misaligned sw");
    do_op(2'b00, 32'h0000_0040, 16'h0000, 0, "R6 word unchanged");
    do_op(2'b00, 32'h0000_0040, 16'h0002, 0, "R6 misaligned lw");
    do_op(2'b10, 32'h0000_0041, 16'h0002, 0, "R6 byte never flagged");
    do_op(2'b01, 32'h0000_1000, 16'h0010, 32'h2468_ACE0, "R8 high bits sw");
    do_op(2'b00, 32'h0000_0000, 16'h0010, 0, "R8 alias lw");

    // R7 back-pressure: held response, refused request
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_op = 2'b00; req_base = 32'h40; req_offset = 0;
    @(negedge clk);
    req_valid = 1; req_op = 2'b01; req_wdata = 32'hFFFF_FFFF; #1;
    check("R7 stall valid", {31'b0, rsp_valid}, 32'd1);
    check("R7 stall ready low", {31'b0, req_ready}, 32'd0);
    check("R7 stall no write", {31'b0, mem_we}, 32'd0);
    check("R7 stall data", rsp_rdata, 32'h8112_9334);
    @(negedge clk); #1;
    check("R7 held data", rsp_rdata, 32'h8112_9334);
    check("R7 held valid", {31'b0, rsp_valid}, 32'd1);
    req_valid = 0; rsp_ready = 1; #1;
    check("R7 ready on rsp_ready", {31'b0, req_ready}, 32'd1);
    @(negedge clk); #1;
    check("R7 rsp drained", {31'b0, rsp_valid}, 32'd0);
    do_op(2'b00, 32'h0000_0040, 16'h0000, 0, "R7 refused store had no effect");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule